// File: doc/BRIEF.md
# Byte ALU with Condition-Code Update

This block is the arithmetic and logic stage of a small accumulator machine. It works on 8-bit operands and also has a 16-bit path for the paired accumulator. In a single combinational pass it takes an operation code, two operands and the current condition bits. It returns the result, the next condition bits, and a write enable. The write enable tells the surrounding datapath whether the result should be written to a register.

The operation code selects one of the operations below. Each one has its own rule for the five condition bits: carry (C), overflow (V), zero (Z), negative (N) and half-carry (H). A bit can be computed from the result, forced to 0 or 1, or passed through from the input unchanged.

The condition vector `ccr_in` and `ccr_out` always uses these positions: bit 4 is H, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.

Instruction decode, the register file and memory access belong to the surrounding datapath. The block holds no state.

Top module: `ccr_alu`

## Requirements
- R1: Code 0 (add) and code 1 (add with carry) form the low byte of a + b, or a + b + C. H is the carry out of bit 3. C is the carry out of bit 7. V is set when both operands have the same sign and the result's sign differs. Z and N follow the result. Bit positions are H=4, N=3, Z=2, V=1, C=0.
- R2: Code 2 (subtract) and code 3 (subtract with borrow) form a − b, or a − b − C. C is set on an unsigned borrow. V is set when the operand signs differ and the result's sign differs from a. Z and N follow the result. H is unchanged.
- R3: Code 14 (word add) and code 15 (word subtract) work on all 16 bits with the carry, borrow and overflow rules of R1 and R2. They update C, V, Z and N and leave H unchanged.
- R4: Code 4 (increment) and code 5 (decrement) add or subtract one from the low byte. They leave C unchanged. V is set when the result crosses 0x7F to 0x80, or 0x80 to 0x7F. Z and N follow the result.
- R5: Code 6 (AND), code 7 (OR) and code 8 (XOR) combine the low bytes. They clear V, leave C unchanged and update Z and N.
- R6: Code 9 (complement) returns the inverted low byte of a. It sets C, clears V and updates Z and N.
- R7: Code 10 (negate) returns 0 − a. C is set unless the result is zero. V is set only for a = 0x80. Z and N follow the result.
- R8: Code 11 (test) and code 12 (compare) drive wr_en low. Test clears C and V and takes Z and N from a, with result equal to a. Compare sets the flags as R2 does for a − b, and shows a − b on result.
- R9: Code 13 (pass/load/transfer) returns a. It clears V, leaves C unchanged and updates Z and N.
- R10: Code 16 (shift left) and code 18 (arithmetic shift right, which keeps bit 7) put the bit shifted out into C. They set V to N XOR C of the new values. Z and N follow the result.
- R11: Code 17 (logical shift right) shifts in a zero, moves bit 0 into C, forces N to 0 and so sets V equal to C.
- R12: Code 19 (rotate left) and code 20 (rotate right) rotate through C. The old C enters the vacated bit and the bit leaving the byte becomes the new C. V is N XOR C.
- R13: Every byte operation ignores bits 15:8 of both operands and returns zeros in bits 15:8 of result. H changes only for codes 0 and 1.
- R14: Codes 21 to 31 return a zero result with wr_en low, and ccr_out equals ccr_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 16 | First operand (minuend; source for unary operations) |
| opnd_b | input | 16 | Second operand |
| ccr_in | input | 5 | Present condition bits {H,N,Z,V,C} |
| result | output | 16 | Operation result |
| ccr_out | output | 5 | Next condition bits {H,N,Z,V,C} |
| wr_en | output | 1 | High when result is to be written back |

## Verification
Each operation is tried with operand pairs chosen to sit on a flag boundary. Signed overflow at 0x7F/0x80 separates V from N. Wrap through 0x00/0xFF separates C and Z from plain sums, and a nibble overflow with no byte overflow separates H from C. Each operation is also driven with condition inputs that have C, V or H already set, which shows whether it preserves, clears or forces each bit. Operands with nonzero upper bytes show that the byte path ignores them. Unused codes paired with an all-ones condition vector show that nothing is disturbed.

// File: rtl/ccr_alu_pkg.sv
package ccr_alu_pkg;
  localparam int OP_W  = 5;
  localparam int CC_W  = 5;
  localparam int CC_C  = 0;
  localparam int CC_V  = 1;
  localparam int CC_Z  = 2;
  localparam int CC_N  = 3;
  localparam int CC_H  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_TST  = 5'd11,
    OP_CMP  = 5'd12,
    OP_PASS = 5'd13,
    OP_ADDW = 5'd14,
    OP_SUBW = 5'd15,
    OP_LSL  = 5'd16,
    OP_LSR  = 5'd17,
    OP_ASR  = 5'd18,
    OP_ROL  = 5'd19,
    OP_ROR  = 5'd20
  } alu_op_e;
endpackage

// File: rtl/ccr_addsub.sv
module ccr_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         half,
  output logic         ovf
);
  localparam int HW = W / 2;

  logic [W-1:0] y_eff;
  logic         c0;
  logic [W:0]   full;
  logic [HW:0]  nib;

  assign y_eff = sub ? ~y : y;
  assign c0    = sub ? ~cin : cin;
  assign full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c0};
  assign nib   = {1'b0, x[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, c0};

  assign sum   = full[W-1:0];
  assign carry = sub ? ~full[W] : full[W];
  assign half  = nib[HW];
  assign ovf   = (x[W-1] == y_eff[W-1]) && (full[W-1] != x[W-1]);
endmodule

// File: rtl/ccr_logic.sv
module ccr_logic
  import ccr_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  always_comb begin
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  r = ~a;
      default: r = a;
    endcase
  end
endmodule

// File: rtl/ccr_shift.sv
module ccr_shift
  import ccr_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         cout
);
  always_comb begin
    case (op)
      OP_LSL: begin r = {a[W-2:0], 1'b0};   cout = a[W-1]; end
      OP_LSR: begin r = {1'b0, a[W-1:1]};   cout = a[0];   end
      OP_ASR: begin r = {a[W-1], a[W-1:1]}; cout = a[0];   end
      OP_ROL: begin r = {a[W-2:0], cin};    cout = a[W-1]; end
      OP_ROR: begin r = {cin, a[W-1:1]};    cout = a[0];   end
      default: begin r = a; cout = cin; end
    endcase
  end
endmodule

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_sel,
  input  logic [2*W-1:0]  opnd_a,
  input  logic [2*W-1:0]  opnd_b,
  input  logic [CC_W-1:0] ccr_in,
  output logic [2*W-1:0]  result,
  output logic [CC_W-1:0] ccr_out,
  output logic            wr_en
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  logic [W-1:0] a8, b8;
  assign a8 = opnd_a[W-1:0];
  assign b8 = opnd_b[W-1:0];

  // byte adder operand steering
  logic [W-1:0] bx, by;
  logic         bcin, bsub;
  always_comb begin
    bx = a8; by = b8; bcin = 1'b0; bsub = 1'b0;
    case (op)
      OP_ADC: bcin = ccr_in[CC_C];
      OP_SUB, OP_CMP: bsub = 1'b1;
      OP_SBC: begin bsub = 1'b1; bcin = ccr_in[CC_C]; end
      OP_INC: by = ONE;
      OP_DEC: begin by = ONE; bsub = 1'b1; end
      OP_NEG: begin bx = '0; by = a8; bsub = 1'b1; end
      default: ;
    endcase
  end

  logic [W-1:0] s8;
  logic         c8, h8, v8;
  ccr_addsub #(.W(W)) u_byte_add (
    .x(bx), .y(by), .cin(bcin), .sub(bsub),
    .sum(s8), .carry(c8), .half(h8), .ovf(v8)
  );

  logic [DW-1:0] s16;
  logic          c16, v16, h16_unused;
  ccr_addsub #(.W(DW)) u_word_add (
    .x(opnd_a), .y(opnd_b), .cin(1'b0), .sub(op == OP_SUBW),
    .sum(s16), .carry(c16), .half(h16_unused), .ovf(v16)
  );

  logic [W-1:0] l8;
  ccr_logic #(.W(W)) u_logic (.op(op), .a(a8), .b(b8), .r(l8));

  logic [W-1:0] sh8;
  logic         shc;
  ccr_shift #(.W(W)) u_shift (
    .op(op), .a(a8), .cin(ccr_in[CC_C]), .r(sh8), .cout(shc)
  );

  logic [W-1:0] r8;
  logic [CC_W-1:0] f;
  logic is_word, is_byte;

  always_comb begin
    f = ccr_in;
    r8 = '0;
    is_word = 1'b0;
    is_byte = 1'b1;
    wr_en = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        r8 = s8; f[CC_H] = h8; f[CC_C] = c8; f[CC_V] = v8;
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        r8 = s8; f[CC_C] = c8; f[CC_V] = v8;
      end
      OP_CMP: begin
        r8 = s8; f[CC_C] = c8; f[CC_V] = v8; wr_en = 1'b0;
      end
      OP_INC, OP_DEC: begin
        r8 = s8; f[CC_V] = v8;
      end
      OP_AND, OP_OR, OP_XOR, OP_PASS: begin
        r8 = l8; f[CC_V] = 1'b0;
      end
      OP_COM: begin
        r8 = l8; f[CC_C] = 1'b1; f[CC_V] = 1'b0;
      end
      OP_TST: begin
        r8 = a8; f[CC_C] = 1'b0; f[CC_V] = 1'b0; wr_en = 1'b0;
      end
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
        r8 = sh8; f[CC_C] = shc; f[CC_V] = sh8[W-1] ^ shc;
      end
      OP_ADDW, OP_SUBW: begin
        is_word = 1'b1; is_byte = 1'b0;
        f[CC_C] = c16; f[CC_V] = v16;
      end
      default: begin
        is_byte = 1'b0; wr_en = 1'b0;
      end
    endcase
    if (is_word) begin
      f[CC_Z] = (s16 == '0);
      f[CC_N] = s16[DW-1];
    end else if (is_byte) begin
      f[CC_Z] = (r8 == '0);
      f[CC_N] = r8[W-1];
    end
  end

  assign result  = is_word ? s16 : {{W{1'b0}}, r8};
  assign ccr_out = f;

  always_comb begin
    // R6
    com_flags_chk: assert (op != OP_COM || (ccr_out[CC_C] && !ccr_out[CC_V]));
    // R11
    lsr_sign_chk: assert (op != OP_LSR || (!ccr_out[CC_N] && ccr_out[CC_V] == ccr_out[CC_C]));
    // R13
    half_keep_chk: assert (op == OP_ADD || op == OP_ADC || ccr_out[CC_H] == ccr_in[CC_H]);
    // R13
    narrow_result_chk: assert (op == OP_ADDW || op == OP_SUBW || result[DW-1:W] == '0);
    // R4
    carry_keep_chk: assert (!(op == OP_INC || op == OP_DEC || op == OP_AND || op == OP_OR ||
                              op == OP_XOR || op == OP_PASS) || ccr_out[CC_C] == ccr_in[CC_C]);
    // R14
    idle_op_chk: assert (op_sel <= 5'd20 || (ccr_out == ccr_in && !wr_en && result == '0));
    // R8
    no_write_chk: assert (!(op == OP_TST || op == OP_CMP) || !wr_en);
  end
endmodule

// File: tb/ccr_alu_bench.sv
module ccr_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]  op_sel;
  logic [15:0] opnd_a, opnd_b;
  logic [4:0]  ccr_in;
  logic [15:0] result;
  logic [4:0]  ccr_out;
  logic        wr_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ccr_alu u_ccr_alu (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .ccr_in(ccr_in),
    .result(result), .ccr_out(ccr_out), .wr_en(wr_en)
  );

  task automatic run(input string req, input logic [4:0] op, input logic [15:0] a,
                     input logic [15:0] b, input logic [4:0] cc,
                     input logic [15:0] exp_r, input logic [4:0] exp_cc, input logic exp_we);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; ccr_in = cc;
    @(posedge clk);
    #(CLK_PERIOD/4);
    n_chk++;
    if (result !== exp_r || ccr_out !== exp_cc || wr_en !== exp_we) begin
      n_bad++;
      $display("FAIL %s op=%0d: result=%h ccr=%b we=%b expected result=%h ccr=%b we=%b",
               req, op, result, ccr_out, wr_en, exp_r, exp_cc, exp_we);
    end
  endtask

  task automatic t_reset();
    run("R1", 5'd0, 16'h0000, 16'h0000, 5'h00, 16'h0000, 5'h04, 1'b1);
  endtask
  task automatic t_add();
    run("R1", 5'd0, 16'h003A, 16'h0028, 5'h00, 16'h0062, 5'h10, 1'b1);
    run("R1", 5'd0, 16'h007F, 16'h0001, 5'h00, 16'h0080, 5'h1A, 1'b1);
    run("R1", 5'd0, 16'h00FF, 16'h0001, 5'h00, 16'h0000, 5'h15, 1'b1);
    run("R1", 5'd1, 16'h0010, 16'h0020, 5'h01, 16'h0031, 5'h00, 1'b1);
  endtask
  task automatic t_sub();
    run("R2", 5'd2, 16'h0005, 16'h0007, 5'h10, 16'h00FE, 5'h19, 1'b1);
    run("R2", 5'd2, 16'h0080, 16'h0001, 5'h00, 16'h007F, 5'h02, 1'b1);
    run("R2", 5'd3, 16'h0050, 16'h004F, 5'h01, 16'h0000, 5'h04, 1'b1);
  endtask
  task automatic t_word();
    run("R3", 5'd14, 16'h7FFF, 16'h0001, 5'h10, 16'h8000, 5'h1A, 1'b1);
    run("R3", 5'd15, 16'h1234, 16'h1234, 5'h00, 16'h0000, 5'h04, 1'b1);
    run("R3", 5'd14, 16'hFFFF, 16'h0002, 5'h00, 16'h0001, 5'h01, 1'b1);
  endtask
  task automatic t_incdec();
    run("R4", 5'd4, 16'h007F, 16'h0000, 5'h01, 16'h0080, 5'h0B, 1'b1);
    run("R4", 5'd5, 16'h0080, 16'h0000, 5'h00, 16'h007F, 5'h02, 1'b1);
    run("R4", 5'd5, 16'h0000, 16'h0000, 5'h00, 16'h00FF, 5'h08, 1'b1);
    run("R4", 5'd4, 16'h00FF, 16'h0000, 5'h00, 16'h0000, 5'h04, 1'b1);
  endtask
  task automatic t_logic();
    run("R5", 5'd6, 16'h00F0, 16'h003C, 5'h03, 16'h0030, 5'h01, 1'b1);
    run("R5", 5'd7, 16'h0080, 16'h0001, 5'h00, 16'h0081, 5'h08, 1'b1);
    run("R5", 5'd8, 16'h005A, 16'h005A, 5'h02, 16'h0000, 5'h04, 1'b1);
  endtask
  task automatic t_com();
    run("R6", 5'd9, 16'h00FF, 16'h0000, 5'h02, 16'h0000, 5'h05, 1'b1);
    run("R6", 5'd9, 16'h000F, 16'h0000, 5'h00, 16'h00F0, 5'h09, 1'b1);
  endtask
  task automatic t_neg();
    run("R7", 5'd10, 16'h0001, 16'h0000, 5'h00, 16'h00FF, 5'h09, 1'b1);
    run("R7", 5'd10, 16'h0080, 16'h0000, 5'h00, 16'h0080, 5'h0B, 1'b1);
    run("R7", 5'd10, 16'h0000, 16'h0000, 5'h01, 16'h0000, 5'h04, 1'b1);
  endtask
  task automatic t_tstcmp();
    run("R8", 5'd11, 16'h0080, 16'h0000, 5'h03, 16'h0080, 5'h08, 1'b0);
    run("R8", 5'd12, 16'h0010, 16'h0020, 5'h00, 16'h00F0, 5'h09, 1'b0);
    run("R8", 5'd12, 16'h0042, 16'h0042, 5'h00, 16'h0000, 5'h04, 1'b0);
  endtask
  task automatic t_pass();
    run("R9", 5'd13, 16'h0000, 16'h0055, 5'h03, 16'h0000, 5'h05, 1'b1);
    run("R9", 5'd13, 16'h009C, 16'h0000, 5'h00, 16'h009C, 5'h08, 1'b1);
  endtask
  task automatic t_shift();
    run("R10", 5'd16, 16'h0081, 16'h0000, 5'h00, 16'h0002, 5'h03, 1'b1);
    run("R10", 5'd16, 16'h0040, 16'h0000, 5'h00, 16'h0080, 5'h0A, 1'b1);
    run("R10", 5'd18, 16'h0081, 16'h0000, 5'h00, 16'h00C0, 5'h09, 1'b1);
    run("R10", 5'd18, 16'h0001, 16'h0000, 5'h00, 16'h0000, 5'h07, 1'b1);
  endtask
  task automatic t_lsr();
    run("R11", 5'd17, 16'h0081, 16'h0000, 5'h08, 16'h0040, 5'h03, 1'b1);
    run("R11", 5'd17, 16'h0002, 16'h0000, 5'h08, 16'h0001, 5'h00, 1'b1);
  endtask
  task automatic t_rot();
    run("R12", 5'd19, 16'h0080, 16'h0000, 5'h01, 16'h0001, 5'h03, 1'b1);
    run("R12", 5'd20, 16'h0001, 16'h0000, 5'h00, 16'h0000, 5'h07, 1'b1);
    run("R12", 5'd20, 16'h0002, 16'h0000, 5'h01, 16'h0081, 5'h0A, 1'b1);
  endtask
  task automatic t_narrow();
    run("R13", 5'd0, 16'hAB12, 16'hCD03, 5'h00, 16'h0015, 5'h00, 1'b1);
    run("R13", 5'd4, 16'hFF7F, 16'hFFFF, 5'h00, 16'h0080, 5'h0A, 1'b1);
  endtask
  task automatic t_unused();
    run("R14", 5'd21, 16'h1234, 16'h5678, 5'h1F, 16'h0000, 5'h1F, 1'b0);
    run("R14", 5'd31, 16'hFFFF, 16'h0001, 5'h0A, 16'h0000, 5'h0A, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    op_sel = '0; opnd_a = '0; opnd_b = '0; ccr_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_word();
    t_incdec();
    t_logic();
    t_com();
    t_neg();
    t_tstcmp();
    t_pass();
    t_shift();
    t_lsr();
    t_rot();
    t_narrow();
    t_unused();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule